// File: doc/BRIEF.md
# E-Clocked External Memory Bus Master

This block turns a single-beat request stream into accesses on an 8-bit external memory bus timed by an enable clock E. Each bus cycle takes two clocks of the block's own clock: E is high for the first clock and low for the second. Address and the read/write line are launched at the rising edge of E and held through the whole cycle. Read data is sampled from the data input at the rising edge of E that ends the cycle. Write data goes out only while E is low, under an output-enable pin for the pad.

Requests enter on a valid/ready handshake. `req_ready` depends only on the bus phase and never on `req_valid`. It is high during the E-low clock, so a request is taken at the edge where E rises and its cycle starts at once. A requester that sees `req_ready` low must keep `req_valid` and its payload steady until the handshake completes. The response side has no back-pressure: `rsp_valid` pulses for one clock when a request's cycle ends. On a read, the captured byte is presented on `rsp_rdata` in that same clock. If no request is taken at a cycle start, the block runs a dummy read at the last address, so E never stops.

Top module: `emx_bus_master`

## Requirements
- R1: `bus_e` is low in reset and toggles on every clock after reset, so one bus cycle spans two clocks (E high, then E low).
- R2: While reset is applied, `bus_e`=0, `bus_doe`=0, `rsp_valid`=0, `bus_rnw`=1 and `bus_addr`=0. Reset ends in the E-low clock, with `req_ready`=1.
- R3: `bus_addr` and `bus_rnw` change only at a rising edge of `bus_e`, and are stable for both clocks of the cycle.
- R4: `req_ready` is 1 exactly in the E-low clock. A handshake (`req_valid`=1, `req_ready`=1) at an edge puts `req_addr` on `bus_addr` at that edge. At the same edge `bus_rnw` takes the value NOT `req_write`, where 1 means read.
- R5: For a read, the byte on `bus_din` just before the rising E edge that ends the cycle appears on `rsp_rdata`. It appears together with a one-clock `rsp_valid` pulse in the clock after that edge, which is an E-high clock.
- R6: For a write, `bus_dout` takes the request's write data and `bus_doe` rises at the falling E edge of the cycle. `bus_doe` stays 1 through the next E-high clock and drops one clock after the cycle ends, unless the next cycle is also a write.
- R7: A write also ends with a one-clock `rsp_valid` pulse in the clock after its closing rising E edge.
- R8: With `req_valid` held high, requests run in consecutive bus cycles with no idle cycle between them, and their `rsp_valid` pulses come two clocks apart.
- R9: When no request is taken at a cycle start, the block runs a dummy read cycle: `bus_rnw`=1, `bus_addr` keeps its last value, `bus_doe` stays 0 in its E-low clock, and no `rsp_valid` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; two periods per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at the next edge (E-low clock) |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read byte |
| bus_addr | output | ADDR_W | External address |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_e | output | 1 | Enable clock E |
| bus_dout | output | DATA_W | Data to the pad, valid while `bus_doe` is 1 |
| bus_doe | output | 1 | Pad output enable for the data bus |
| bus_din | input | DATA_W | Data from the pad |

## Verification
The bench builds the block with its default 16-bit address and 8-bit data. This lets one request table mix addresses whose high and low bytes both differ. The bench memory answers every read from the current address and latches a write at the rising E edge. As a result, write-then-read pairs, back-to-back streaming across a write, and a dummy read after a write at the same address are all observable at the ports.

// File: rtl/emx_pkg.sv
package emx_pkg;
  parameter int unsigned EMX_AW = 16;
  parameter int unsigned EMX_DW = 8;

  // Bus phase: the clock in which E is high or low.
  typedef enum logic {
    EPH_LOW  = 1'b0,
    EPH_HIGH = 1'b1
  } eph_t;
endpackage

// File: rtl/emx_phase.sv
module emx_phase
  import emx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output eph_t ph,
  output logic cyc_start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= EPH_LOW;
    else        ph <= (ph == EPH_LOW) ? EPH_HIGH : EPH_LOW;
  end

  // The next edge raises E and opens a new bus cycle.
  assign cyc_start = (ph == EPH_LOW);

  // R1: phase alternates on every clock.
  a_r1_phase_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == EPH_LOW) |=> (ph == EPH_HIGH));
  a_r1_phase_alt_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == EPH_HIGH) |=> (ph == EPH_LOW));
endmodule

// File: rtl/emx_cmd.sv
module emx_cmd #(
  parameter int unsigned AW = emx_pkg::EMX_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          take,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rnw,
  output logic          live
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      bus_rnw  <= 1'b1;
      live     <= 1'b0;
    end else if (cyc_start) begin
      if (take) begin
        bus_addr <= req_addr;
        bus_rnw  <= ~req_write;
        live     <= 1'b1;
      end else begin
        bus_rnw  <= 1'b1;   // dummy read, address kept
        live     <= 1'b0;
      end
    end
  end

  // R3: no address or direction change in mid-cycle.
  a_r3_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> ($stable(bus_addr) && $stable(bus_rnw)));
  // R9: an idle cycle start keeps the address and reads.
  a_r9_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !take) |=> ($stable(bus_addr) && bus_rnw && !live));
endmodule

// File: rtl/emx_data.sv
module emx_data
  import emx_pkg::*;
#(
  parameter int unsigned DW = emx_pkg::EMX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  eph_t          ph,
  input  logic          take,
  input  logic [DW-1:0] req_wdata,
  input  logic          bus_rnw,
  input  logic          live,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [DW-1:0] wdat_q;
  logic          end_edge;   // next edge raises E and closes the cycle
  logic          fall_edge;  // next edge drops E

  assign end_edge  = (ph == EPH_LOW);
  assign fall_edge = (ph == EPH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdat_q <= '0;
    else if (take) wdat_q <= req_wdata;
  end

  // Drive side: changes only when E falls, so the enable covers the
  // E-low clock and the E-high clock that follows it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_doe  <= 1'b0;
      bus_dout <= '0;
    end else if (fall_edge) begin
      bus_doe <= ~bus_rnw;
      if (!bus_rnw) bus_dout <= wdat_q;
    end
  end

  // Capture side: sample at the rising E edge that ends the cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= end_edge & live;
      if (end_edge && live && bus_rnw) rsp_rdata <= bus_din;
    end
  end

  // R6: in the E-low clock the pad is driven only for a write.
  a_r6_doe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == EPH_LOW && bus_doe) |-> !bus_rnw);
  // R6: in the E-high clock the enable is only the hold of the last cycle.
  a_r6_doe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == EPH_HIGH && bus_doe) |-> $past(bus_doe));
  // R6: write data stays put while the pad drives it.
  a_r6_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == EPH_LOW && bus_doe) |=> $stable(bus_dout));
endmodule

// File: rtl/emx_bus_master.sv
module emx_bus_master
  import emx_pkg::*;
#(
  parameter int unsigned ADDR_W = EMX_AW,
  parameter int unsigned DATA_W = EMX_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rnw,
  output logic              bus_e,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  eph_t ph;
  logic cyc_start;
  logic take;
  logic live;

  emx_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .cyc_start (cyc_start)
  );

  assign bus_e     = (ph == EPH_HIGH);
  assign req_ready = cyc_start;
  assign take      = req_valid & req_ready;

  emx_cmd #(.AW(ADDR_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .take      (take),
    .req_addr  (req_addr),
    .req_write (req_write),
    .bus_addr  (bus_addr),
    .bus_rnw   (bus_rnw),
    .live      (live)
  );

  emx_data #(.DW(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .take      (take),
    .req_wdata (req_wdata),
    .bus_rnw   (bus_rnw),
    .live      (live),
    .bus_din   (bus_din),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R1: E alternates.
  a_r1_e_alt: assert property (@(posedge clk) disable iff (!rst_n)
    bus_e |=> !bus_e);
  // R4: a taken request owns the bus from the next E-high clock.
  a_r4_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (bus_e && bus_addr == $past(req_addr) && bus_rnw == !$past(req_write)));
  // R5: completion is reported in an E-high clock.
  a_r5_rsp_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> bus_e);
  // R7: completions are single-clock pulses.
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sim_emx_bus_master.sv
module sim_emx_bus_master;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;   // write data, or expected read data
  } vec_t;

  // Unwritten memory holds addr[7:0] ^ 8'h5A.
  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{wr:1'b0, addr:16'h0010, data:8'h4A},
    '{wr:1'b1, addr:16'h0010, data:8'hA5},
    '{wr:1'b0, addr:16'h0010, data:8'hA5},
    '{wr:1'b1, addr:16'h12FF, data:8'h3C},
    '{wr:1'b0, addr:16'h12FF, data:8'h3C},
    '{wr:1'b0, addr:16'hFF00, data:8'h5A},
    '{wr:1'b1, addr:16'hFF00, data:8'h00},
    '{wr:1'b0, addr:16'hFF00, data:8'h00},
    '{wr:1'b1, addr:16'h0001, data:8'hFF},
    '{wr:1'b0, addr:16'h0001, data:8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_write = 1'b0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic bus_rnw, bus_e, bus_doe;
  logic [DW-1:0] bus_dout, bus_din;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  emx_bus_master u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_e(bus_e),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  // Memory model: answers reads from the current address, latches a
  // write at the rising E edge that ends the cycle.
  logic [DW-1:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = DW'(i) ^ 8'h5A;
  assign bus_din = bus_rnw ? mem[bus_addr[7:0]] : 8'hEE;
  always @(posedge clk)
    if (rst_n && !bus_e && bus_doe && !bus_rnw) mem[bus_addr[7:0]] <= bus_dout;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  // One isolated request, checked phase by phase.
  task automatic one_req(input vec_t v);
    wait_ready();
    req_valid = 1'b1; req_addr = v.addr; req_write = v.wr; req_wdata = v.data;
    @(negedge clk);  // taken; E-high clock
    req_valid = 1'b0;
    chk(bus_e == 1'b1, "R4 e high after take", int'(bus_e), 1);
    chk(bus_addr == v.addr, "R4 addr launched", int'(bus_addr), int'(v.addr));
    chk(bus_rnw == !v.wr, "R4 rnw launched", int'(bus_rnw), int'(!v.wr));
    chk(bus_doe == 1'b0, "R6 doe low in high phase", int'(bus_doe), 0);
    @(negedge clk);  // E-low clock
    chk(bus_addr == v.addr, "R3 addr held", int'(bus_addr), int'(v.addr));
    chk(bus_doe == v.wr, "R6 doe in low phase", int'(bus_doe), int'(v.wr));
    if (v.wr) chk(bus_dout == v.data, "R6 dout", int'(bus_dout), int'(v.data));
    @(negedge clk);  // next E-high clock
    chk(rsp_valid == 1'b1, v.wr ? "R7 write done" : "R5 read done", int'(rsp_valid), 1);
    if (!v.wr) chk(rsp_rdata == v.data, "R5 read data", int'(rsp_rdata), int'(v.data));
    chk(bus_doe == v.wr, "R6 doe hold", int'(bus_doe), int'(v.wr));
    @(negedge clk);  // dummy cycle E-low clock
    chk(bus_doe == 1'b0, "R6 doe released", int'(bus_doe), 0);
    chk(rsp_valid == 1'b0, "R5 pulse one clock", int'(rsp_valid), 0);
  endtask

  initial begin
    // R2: reset state.
    repeat (3) @(negedge clk);
    chk(bus_e == 1'b0 && bus_doe == 1'b0 && rsp_valid == 1'b0, "R2 reset outputs",
        {bus_e, bus_doe, rsp_valid}, 0);
    chk(bus_rnw == 1'b1 && bus_addr == '0, "R2 reset bus", int'(bus_addr), 0);
    rst_n = 1'b1;
    chk(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);

    // R1: E toggles every clock.
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(bus_e == k[0] ^ 1'b1, "R1 e alternates", int'(bus_e), int'(k[0] ^ 1'b1));
      chk(req_ready == !bus_e, "R4 ready in low clock", int'(req_ready), int'(!bus_e));
    end

    // Table of isolated requests.
    foreach (TBL[i]) one_req(TBL[i]);

    // R9: idle dummy reads at the last address.
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(bus_addr == 16'h0001 && bus_rnw == 1'b1, "R9 dummy read at last addr",
          int'(bus_addr), 16'h0001);
      chk(rsp_valid == 1'b0 && bus_doe == 1'b0, "R9 no response or drive",
          {rsp_valid, bus_doe}, 0);
    end

    // R8: back-to-back read, read, write.
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0010;
    @(negedge clk);
    chk(bus_addr == 16'h0010, "R8 first addr", int'(bus_addr), 16'h0010);
    req_addr = 16'h12FF;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready again", int'(req_ready), 1);
    @(negedge clk);
    chk(bus_addr == 16'h12FF && bus_rnw, "R8 second addr no gap", int'(bus_addr), 16'h12FF);
    chk(rsp_valid && rsp_rdata == 8'hA5, "R8 first response", int'(rsp_rdata), 8'hA5);
    req_addr = 16'h0020; req_write = 1'b1; req_wdata = 8'h77;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 gap between pulses", int'(rsp_valid), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_addr == 16'h0020 && !bus_rnw, "R8 third addr write", int'(bus_addr), 16'h0020);
    chk(rsp_valid && rsp_rdata == 8'h3C, "R8 second response", int'(rsp_rdata), 8'h3C);
    @(negedge clk);
    chk(bus_doe && bus_dout == 8'h77, "R6 streamed write drive", int'(bus_dout), 8'h77);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R7 streamed write done", int'(rsp_valid), 1);
    @(negedge clk);
    one_req('{wr:1'b0, addr:16'h0020, data:8'h77});

    // R2: reset in the middle of a write drops the drive.
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0030; req_wdata = 8'h11;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    chk(bus_doe == 1'b1, "R6 doe before reset", int'(bus_doe), 1);
    rst_n = 1'b0;
    #1;
    chk(bus_doe == 1'b0 && bus_e == 1'b0 && bus_addr == '0, "R2 async reset",
        int'(bus_addr), 0);
    @(negedge clk); rst_n = 1'b1;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule